// File: doc/BRIEF.md
# Dual-Channel PCM Voice Serial Port

This block is the digital sample interface of a two-channel voice converter. It trades 8-bit companded samples with an external host over three timing lines: a bit clock, a transmit frame sync and a receive frame sync. All of them are oversampled by a free-running system clock. On the transmit side the core supplies one sample per channel. The port captures both samples at the transmit sync and shifts them out most significant bit first. On the receive side the port collects serial bits and hands a pair of samples back to the core with a single-cycle strobe.

A mode input picks the pin layout. In parallel mode (mode = 1) each channel has its own input pin and its own output pin, and the two channels share the same timing. In multiplexed mode (mode = 0) the two channels share one pin pair as a 16-bit frame, channel 1 first. Each output has an enable, so the pads can be built as open-drain or tri-state. An enable is asserted only while its own slot is in progress. A power-enable input and a clock-activity monitor force both directions idle when the port is powered off or its clocks stop.

Top module: `pcm_voice_port`

## Requirements
- R1: After reset both output enables, both data outputs and the receive strobe are 0, and the power-save flag is 1 until the first transmit sync rising edge.
- R2: Receive bits are taken on falling edges of the bit clock, MSB first. The first bit is the one taken on the first falling edge after a receive sync rising edge. When the last bit of the frame is taken, the received pair appears on the receive sample outputs together with a strobe that lasts exactly one system clock cycle.
- R3: At a transmit sync rising edge the port captures both core samples and drives the MSB. Each following bit clock rising edge launches the next bit.
- R4: An output enable is 1 from the transmit sync for exactly the frame's bit count of bit periods, and 0 otherwise. While an enable is 0, its data output is 0.
- R5: In parallel mode (mode = 1), channel 1 is received on input A and sent on output A. Channel 2 uses input B and output B. Both channels use 8-bit slots with the same timing.
- R6: In multiplexed mode (mode = 0), input B carries 16 bits: channel 1 MSB first, then channel 2. Output A sends the same 16-bit layout. Output B's enable stays 0, and input A has no effect on the received samples.
- R7: While the power-enable input is 0, both output enables stay 0 and no receive strobe is produced.
- R8: The power-save flag is set if no bit clock edge occurs for BCLK_LIM system cycles, or if no transmit sync rising edge occurs for SYNC_LIM cycles. While the flag is set, both output enables are 0.
- R9: Only a transmit sync rising edge clears the power-save flag. The frame that begins at that same sync is transmitted and received in full.
- R10: Bit clock edges after the 8th bit (parallel mode) or the 16th bit (multiplexed mode) are ignored until the next sync. They do not change the delivered samples, produce no second strobe and do not extend the enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples all port lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| bclk_i | input | 1 | Serial bit clock |
| xsync_i | input | 1 | Transmit frame sync |
| rsync_i | input | 1 | Receive frame sync |
| din_a_i | input | 1 | Serial data input A (channel 1 in parallel mode) |
| din_b_i | input | 1 | Serial data input B (channel 2, or both channels multiplexed) |
| par_mode_i | input | 1 | 1 = parallel pins, 0 = 16-bit multiplexed frame |
| pwr_en_i | input | 1 | 0 = power down both directions |
| tx_ch1_i | input | 8 | Channel 1 sample from the core |
| tx_ch2_i | input | 8 | Channel 2 sample from the core |
| dout_a_o | output | 1 | Serial data output A |
| dout_a_oe_o | output | 1 | Drive enable for output A |
| dout_b_o | output | 1 | Serial data output B |
| dout_b_oe_o | output | 1 | Drive enable for output B |
| rx_ch1_o | output | 8 | Received channel 1 sample |
| rx_ch2_o | output | 8 | Received channel 2 sample |
| rx_valid_o | output | 1 | One-cycle strobe marking a new received pair |
| psave_o | output | 1 | Clock-loss power-save flag |

## Verification
Two functions can fall in the same cycle: clearing the power-save flag and starting a new frame, because the sync edge that releases power save is also the edge that launches the frame. The bench first stops the bit clock, and later withholds the transmit sync while the bit clock keeps running, until the flag sets each time. It then sends a full frame whose first sync must both clear the flag and start transmission. It judges this by requiring the MSB, every later bit, the enable window and the received pair of that first frame to be exact. The other pair of functions is the last receive bit of a frame and the idle bit clock edges that follow it. The bench keeps toggling the clock with junk data after the frame and checks that only the framed bits are delivered, with a single strobe.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;

    // Edge events decoded from the oversampled port lines
    typedef struct packed {
        logic bclk_rise;
        logic bclk_fall;
        logic xsync_rise;
        logic rsync_rise;
    } pcm_edges_t;

    // Registered copies of the port lines and their previous values
    typedef struct packed {
        logic bclk;
        logic bclk_p;
        logic xs;
        logic xs_p;
        logic rs;
        logic rs_p;
        logic da;
        logic db;
        logic par;
        logic pwr;
    } pcm_samp_t;

endpackage

// File: rtl/pcm_activity_mon.sv
module pcm_activity_mon #(
    parameter int BCLK_LIM = 64,
    parameter int SYNC_LIM = 8192
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk_edge,
    input  logic sync_rise,
    output logic psave_q_o,
    output logic psave_d_o
);
    localparam int BW = $clog2(BCLK_LIM + 1);
    localparam int SW = $clog2(SYNC_LIM + 1);

    typedef struct packed {
        logic [BW-1:0] bc;
        logic [SW-1:0] sc;
        logic          ps;
    } mon_t;

    mon_t d, q;
    logic lost;

    always_comb begin
        d = q;
        if (bclk_edge)                      d.bc = '0;
        else if (q.bc != BW'(BCLK_LIM))     d.bc = q.bc + 1'b1;
        if (sync_rise)                      d.sc = '0;
        else if (q.sc != SW'(SYNC_LIM))     d.sc = q.sc + 1'b1;
        lost = (!bclk_edge && q.bc == BW'(BCLK_LIM)) ||
               (!sync_rise && q.sc == SW'(SYNC_LIM));
        if (lost)           d.ps = 1'b1;
        else if (sync_rise) d.ps = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{bc: '0, sc: '0, ps: 1'b1};
        else        q <= d;
    end

    assign psave_q_o = q.ps;
    assign psave_d_o = d.ps;

    AST_AWAKE_WHILE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (q.bc < BW'(BCLK_LIM) && q.sc < SW'(SYNC_LIM) && !q.ps) |=> !q.ps); // R8
    AST_RELEASE_ONLY_ON_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ps && !sync_rise) |=> q.ps); // R9
endmodule

// File: rtl/pcm_rx_deser.sv
module pcm_rx_deser #(
    parameter int SAMP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              par_i,
    input  logic              sync_rise,
    input  logic              bclk_fall,
    input  logic              din_a,
    input  logic              din_b,
    output logic [SAMP_W-1:0] rx1_o,
    output logic [SAMP_W-1:0] rx2_o,
    output logic              vld_o
);
    localparam int FW    = 2 * SAMP_W;
    localparam int CNT_W = $clog2(FW + 1);

    typedef struct packed {
        logic [SAMP_W-1:0] sh_a;
        logic [FW-1:0]     sh_b;
        logic [CNT_W-1:0]  cnt;
        logic              act;
        logic              par;
        logic [SAMP_W-1:0] o1;
        logic [SAMP_W-1:0] o2;
        logic              vld;
    } rx_t;

    rx_t d, q;
    logic              act_now, par_now;
    logic [CNT_W-1:0]  cnt_now;
    logic [SAMP_W-1:0] na;
    logic [FW-1:0]     nb;

    always_comb begin
        d       = q;
        d.vld   = 1'b0;
        act_now = q.act;
        cnt_now = q.cnt;
        par_now = q.par;
        na      = {q.sh_a[SAMP_W-2:0], din_a};
        nb      = {q.sh_b[FW-2:0], din_b};
        if (!run) begin
            d.act = 1'b0;
        end else begin
            if (sync_rise) begin
                act_now = 1'b1;
                cnt_now = '0;
                par_now = par_i;
            end
            d.act = act_now;
            d.cnt = cnt_now;
            d.par = par_now;
            if (bclk_fall && act_now) begin
                d.sh_a = na;
                d.sh_b = nb;
                if (cnt_now == (par_now ? CNT_W'(SAMP_W - 1) : CNT_W'(FW - 1))) begin
                    d.act = 1'b0;
                    d.vld = 1'b1;
                    if (par_now) begin
                        d.o1 = na;
                        d.o2 = nb[SAMP_W-1:0];
                    end else begin
                        d.o1 = nb[FW-1:SAMP_W];
                        d.o2 = nb[SAMP_W-1:0];
                    end
                end else begin
                    d.cnt = cnt_now + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rx1_o = q.o1;
    assign rx2_o = q.o2;
    assign vld_o = q.vld;

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        q.vld |=> !q.vld); // R2
    AST_RX_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        q.act |-> q.cnt <= CNT_W'(FW - 1)); // R10
endmodule

// File: rtl/pcm_tx_ser.sv
module pcm_tx_ser #(
    parameter int SAMP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              par_i,
    input  logic              sync_rise,
    input  logic              bclk_rise,
    input  logic [SAMP_W-1:0] samp1_i,
    input  logic [SAMP_W-1:0] samp2_i,
    output logic              dout_a_o,
    output logic              oe_a_o,
    output logic              dout_b_o,
    output logic              oe_b_o
);
    localparam int FW    = 2 * SAMP_W;
    localparam int CNT_W = $clog2(FW + 1);

    typedef struct packed {
        logic [FW-1:0]     sh_a;
        logic [SAMP_W-1:0] sh_b;
        logic [CNT_W-1:0]  cnt;
        logic              act;
        logic              par;
    } tx_t;

    tx_t d, q;
    logic [CNT_W-1:0] last;

    always_comb begin
        d    = q;
        last = q.par ? CNT_W'(SAMP_W - 1) : CNT_W'(FW - 1);
        if (!run) begin
            d.act = 1'b0;
        end else if (sync_rise) begin
            d.act = 1'b1;
            d.cnt = '0;
            d.par = par_i;
            if (par_i) begin
                d.sh_a = {samp1_i, {SAMP_W{1'b0}}};
                d.sh_b = samp2_i;
            end else begin
                d.sh_a = {samp1_i, samp2_i};
                d.sh_b = '0;
            end
        end else if (bclk_rise && q.act) begin
            if (q.cnt == last) begin
                d.act = 1'b0;
            end else begin
                d.cnt  = q.cnt + 1'b1;
                d.sh_a = {q.sh_a[FW-2:0], 1'b0};
                d.sh_b = {q.sh_b[SAMP_W-2:0], 1'b0};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign oe_a_o   = q.act;
    assign oe_b_o   = q.act & q.par;
    assign dout_a_o = q.act & q.sh_a[FW-1];
    assign dout_b_o = q.act & q.par & q.sh_b[SAMP_W-1];

    AST_SLOT_OPENS_AT_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.act) |-> $past(sync_rise)); // R3
    AST_TX_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        q.act |-> q.cnt <= last); // R10
endmodule

// File: rtl/pcm_voice_port.sv
module pcm_voice_port #(
    parameter int SAMP_W   = 8,
    parameter int BCLK_LIM = 64,
    parameter int SYNC_LIM = 8192
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bclk_i,
    input  logic              xsync_i,
    input  logic              rsync_i,
    input  logic              din_a_i,
    input  logic              din_b_i,
    input  logic              par_mode_i,
    input  logic              pwr_en_i,
    input  logic [SAMP_W-1:0] tx_ch1_i,
    input  logic [SAMP_W-1:0] tx_ch2_i,
    output logic              dout_a_o,
    output logic              dout_a_oe_o,
    output logic              dout_b_o,
    output logic              dout_b_oe_o,
    output logic [SAMP_W-1:0] rx_ch1_o,
    output logic [SAMP_W-1:0] rx_ch2_o,
    output logic              rx_valid_o,
    output logic              psave_o
);
    import pcm_port_pkg::*;

    pcm_samp_t  s_d, s_q;
    pcm_edges_t ev;
    logic       psave_nxt, run;

    always_comb begin
        s_d        = s_q;
        s_d.bclk   = bclk_i;
        s_d.bclk_p = s_q.bclk;
        s_d.xs     = xsync_i;
        s_d.xs_p   = s_q.xs;
        s_d.rs     = rsync_i;
        s_d.rs_p   = s_q.rs;
        s_d.da     = din_a_i;
        s_d.db     = din_b_i;
        s_d.par    = par_mode_i;
        s_d.pwr    = pwr_en_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ev.bclk_rise  =  s_q.bclk & ~s_q.bclk_p;
    assign ev.bclk_fall  = ~s_q.bclk &  s_q.bclk_p;
    assign ev.xsync_rise =  s_q.xs   & ~s_q.xs_p;
    assign ev.rsync_rise =  s_q.rs   & ~s_q.rs_p;
    assign run           =  s_q.pwr  & ~psave_nxt;

    pcm_activity_mon #(.BCLK_LIM(BCLK_LIM), .SYNC_LIM(SYNC_LIM)) u_mon (
        .clk       (clk),
        .rst_n     (rst_n),
        .bclk_edge (ev.bclk_rise | ev.bclk_fall),
        .sync_rise (ev.xsync_rise),
        .psave_q_o (psave_o),
        .psave_d_o (psave_nxt)
    );

    pcm_tx_ser #(.SAMP_W(SAMP_W)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .par_i     (s_q.par),
        .sync_rise (ev.xsync_rise),
        .bclk_rise (ev.bclk_rise),
        .samp1_i   (tx_ch1_i),
        .samp2_i   (tx_ch2_i),
        .dout_a_o  (dout_a_o),
        .oe_a_o    (dout_a_oe_o),
        .dout_b_o  (dout_b_o),
        .oe_b_o    (dout_b_oe_o)
    );

    pcm_rx_deser #(.SAMP_W(SAMP_W)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .par_i     (s_q.par),
        .sync_rise (ev.rsync_rise),
        .bclk_fall (ev.bclk_fall),
        .din_a     (s_q.da),
        .din_b     (s_q.db),
        .rx1_o     (rx_ch1_o),
        .rx2_o     (rx_ch2_o),
        .vld_o     (rx_valid_o)
    );

    AST_POWER_DOWN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.pwr |=> (!dout_a_oe_o && !dout_b_oe_o && !rx_valid_o)); // R7
    AST_SAVE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        psave_o |-> (!dout_a_oe_o && !dout_b_oe_o)); // R8
endmodule

// File: tb/pcm_voice_port_bench.sv
module pcm_voice_port_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bclk = 0, xs = 0, rs = 0, da = 0, db = 0, par = 1, pwr = 1;
    logic [7:0] t1 = '0, t2 = '0;
    logic dout_a, oe_a, dout_b, oe_b, vld, psave;
    logic [7:0] r1, r2;

    int checks = 0, fails = 0, vcount = 0;
    logic [7:0] cap1 = '0, cap2 = '0;

    always #10 clk = ~clk;

    pcm_voice_port #(.SAMP_W(8), .BCLK_LIM(32), .SYNC_LIM(400)) u_pcm_voice_port (
        .clk(clk), .rst_n(rst_n), .bclk_i(bclk), .xsync_i(xs), .rsync_i(rs),
        .din_a_i(da), .din_b_i(db), .par_mode_i(par), .pwr_en_i(pwr),
        .tx_ch1_i(t1), .tx_ch2_i(t2), .dout_a_o(dout_a), .dout_a_oe_o(oe_a),
        .dout_b_o(dout_b), .dout_b_oe_o(oe_b), .rx_ch1_o(r1), .rx_ch2_o(r2),
        .rx_valid_o(vld), .psave_o(psave));

    always @(negedge clk) if (vld) begin
        cap1 <= r1; cap2 <= r2; vcount <= vcount + 1;
    end

    // mode, tx ch1, tx ch2, rx ch1, rx ch2
    localparam logic [32:0] VEC [6] = '{
        {1'b1, 8'hA5, 8'h3C, 8'h81, 8'h7E},
        {1'b1, 8'h00, 8'hFF, 8'hFF, 8'h00},
        {1'b0, 8'hC3, 8'h5A, 8'h12, 8'hED},
        {1'b0, 8'h80, 8'h01, 8'h01, 8'h80},
        {1'b1, 8'h7F, 8'h80, 8'h55, 8'hAA},
        {1'b0, 8'hFF, 8'h00, 8'h00, 8'hFF}
    };

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic half();
        repeat (4) @(negedge clk);
    endtask

    // One frame of 20 bit periods; off=1 expects a silent port (power down)
    task automatic frame(input logic m, input logic [7:0] a1, a2, b1, b2, input logic off);
        int n;
        int v0;
        logic [15:0] txs, rxs;
        n = m ? 8 : 16;
        v0 = vcount;
        par = m; t1 = a1; t2 = a2;
        txs = {a1, a2};
        rxs = {b1, b2};
        for (int i = 0; i < 20; i++) begin
            bclk = 1'b1;
            if (i == 0) begin xs = 1'b1; rs = 1'b1; end
            if (i == 1) begin xs = 1'b0; rs = 1'b0; end
            if (m) begin
                da = (i < 8) ? b1[7-i] : ~b1[i%8];
                db = (i < 8) ? b2[7-i] : b2[i%8];
            end else begin
                da = ~da;
                db = (i < 16) ? rxs[15-i] : ~rxs[i%16];
            end
            half();
            if (off) begin
                chk(!oe_a && !oe_b, "R7 oe in power down", {oe_a, oe_b}, 0);
            end else begin
                chk(oe_a == (i < n), "R4 oe_a window", oe_a, (i < n));
                chk(oe_b == (m && i < n), m ? "R5 oe_b window" : "R6 oe_b quiet", oe_b, (m && i < n));
                if (i < n) begin
                    if (m) begin
                        chk(dout_a == a1[7-i], "R5 R3 dout_a bit", dout_a, a1[7-i]);
                        chk(dout_b == a2[7-i], "R5 R3 dout_b bit", dout_b, a2[7-i]);
                    end else begin
                        chk(dout_a == txs[15-i], "R6 R3 dout_a bit", dout_a, txs[15-i]);
                    end
                end else begin
                    chk(!dout_a && !dout_b, "R4 R10 data quiet after slot", {dout_a, dout_b}, 0);
                end
            end
            bclk = 1'b0;
            half();
        end
        if (off) begin
            chk(vcount == v0, "R7 no strobe", vcount - v0, 0);
        end else begin
            chk(vcount == v0 + 1, "R2 R10 one strobe", vcount - v0, 1);
            chk(cap1 == b1, m ? "R5 rx ch1" : "R6 rx ch1", cap1, b1);
            chk(cap2 == b2, m ? "R5 rx ch2" : "R6 rx ch2", cap2, b2);
        end
    endtask

    initial begin
        #(200000 * 20);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        chk(!oe_a && !oe_b && !dout_a && !dout_b && !vld, "R1 outputs idle in reset",
            {oe_a, oe_b, dout_a, dout_b, vld}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(psave == 1'b1, "R1 psave after reset", psave, 1);
        chk(!oe_a && !oe_b && !vld, "R1 idle after reset", {oe_a, oe_b, vld}, 0);

        // First frame: the sync that clears psave also starts the frame (R9)
        for (int k = 0; k < 6; k++)
            frame(VEC[k][32], VEC[k][31:24], VEC[k][23:16], VEC[k][15:8], VEC[k][7:0], 1'b0);
        chk(psave == 1'b0, "R9 psave cleared", psave, 0);

        // Bit clock stops
        repeat (60) @(negedge clk);
        chk(psave == 1'b1, "R8 bclk loss", psave, 1);
        chk(!oe_a && !oe_b, "R8 oe low in save", {oe_a, oe_b}, 0);
        frame(1'b0, 8'h96, 8'h69, 8'h3E, 8'hC1, 1'b0);
        chk(psave == 1'b0, "R9 resume after bclk loss", psave, 0);

        // Sync withheld while bit clock runs
        for (int i = 0; i < 40; i++) begin
            bclk = 1'b1; half(); bclk = 1'b0; half();
        end
        chk(psave == 1'b1, "R8 sync loss", psave, 1);
        chk(!oe_a && !oe_b, "R8 oe low in sync loss", {oe_a, oe_b}, 0);
        frame(1'b1, 8'h1D, 8'hE2, 8'h4B, 8'hB4, 1'b0);
        chk(psave == 1'b0, "R9 resume after sync loss", psave, 0);

        // Power down
        pwr = 1'b0;
        frame(1'b1, 8'hF0, 8'h0F, 8'h33, 8'hCC, 1'b1);
        pwr = 1'b1;
        frame(1'b1, 8'hF0, 8'h0F, 8'h33, 8'hCC, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule